// File: doc/BRIEF.md
# Oscillator-Fail Flag and Interrupt Pin Logic

This block supervises the oscillator of a real-time clock and drives the single active-low, open-drain interrupt/output pin. It keeps a sticky fail flag. The flag is raised at power-on, on any cycle where the oscillator reports that it is not running, and whenever software holds the stop control. A small run timer counts one-second ticks while the oscillator runs freely. Software may clear the flag only after that timer has reached its limit.

The pin works in one of two modes. In interrupt mode it is the OR of three gated sources: the fail flag, an alarm request and a watchdog request. When none of the three enables is set, the pin shows a general-purpose output bit instead. The block drives only a pull-low enable, and an external pull-up supplies the high level. Software reaches the control and flag bits through a one-bit-address write/read strobe port.

Top module: `osc_fail_irq`

## Requirements
- R1: After reset the fail flag reads 1, STOP, OFIE and AFE read 0, OUT reads 1, stop_o is 0, pull_low_o is 0 and rdata_o is 0.
- R2: A clock edge that sees osc_run_i low sets the fail flag and restarts the run timer from zero, whatever the host does in that cycle. Ticks seen while osc_run_i is low do not advance the timer.
- R3: A control write (addr_i=0) with wdata_i[0]=1 sets STOP, drives stop_o high and sets the fail flag. While STOP is 1 the run timer is held at zero. A later control write with wdata_i[0]=0 releases stop_o.
- R4: The fail flag is sticky. Only a flag write (addr_i=1) with wdata_i[0]=0 can clear it. A flag write with wdata_i[0]=1 and any read leave the flag and the pin unchanged.
- R5: A clear is honoured only once RUN_TICKS (default 4) ticks have been counted with the oscillator running and STOP at 0 since the last stop. An earlier clear is ignored.
- R6: If a set condition and an honoured clear fall on the same edge, the flag ends at 1.
- R7: With OFIE=1 and the fail flag at 1, pull_low_o is 1. Clearing OFIE or the flag releases the pin when no other source is active.
- R8: In interrupt mode (OFIE, AFE or wdog_en_i set), pull_low_o = (OF&OFIE) | (alm_req_i&AFE) | (wdog_req_i&wdog_en_i).
- R9: With OFIE, AFE and wdog_en_i all 0, pull_low_o is the inverse of OUT: OUT=0 pulls the pin low and OUT=1 releases it.
- R10: A rd_i pulse loads rdata_o on that edge. Control reads give {OUT,AFE,OFIE,STOP} in bits 3..0. Flag reads give the fail flag in bit 0 and the run-timer-saturated indication in bit 1, with the upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_run_i | input | 1 | High while the oscillator is running |
| tick_i | input | 1 | One-cycle pulse once per second |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 1 | 0 = control register, 1 = flag register |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data, registered on rd_i |
| alm_req_i | input | 1 | Alarm interrupt request |
| wdog_req_i | input | 1 | Watchdog interrupt request |
| wdog_en_i | input | 1 | Watchdog configured to interrupt |
| stop_o | output | 1 | Oscillator stop control |
| pull_low_o | output | 1 | Open-drain pull-low enable for the pin |

## Verification
A corrupted fail flag or enable bit shows on pull_low_o in the same cycle whenever the affected source is armed. It shows on a flag read one cycle after the rd_i pulse. A run timer that counts too early, counts too late or fails to restart is visible only through the outcome of a clear attempt. The bench therefore probes it with clears placed one tick before and exactly at the saturation point, after each kind of stop.

// File: rtl/ofi_pkg.sv
package ofi_pkg;
  localparam int DATA_W    = 4;
  localparam logic CTRL_ADDR = 1'b0;
  localparam logic FLAG_ADDR = 1'b1;
  localparam int STOP_B  = 0;
  localparam int OF_B    = 0;
  localparam int RUNOK_B = 1;
  localparam int N_SRC   = 3;
  localparam int SRC_OF  = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_WDG = 2;

  typedef struct packed {
    logic out_bit;
    logic afe;
    logic ofie;
    logic stop;
  } ctrl_t;
endpackage

// File: rtl/ofi_ctrl_regs.sv
module ofi_ctrl_regs
  import ofi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic              stop_wr_o
);
  logic ctrl_wr;
  assign ctrl_wr   = wr_i && (addr_i == CTRL_ADDR);
  assign stop_wr_o = ctrl_wr && wdata_i[STOP_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '{out_bit: 1'b1, afe: 1'b0, ofie: 1'b0, stop: 1'b0};
    end else if (ctrl_wr) begin
      ctrl_o <= ctrl_t'(wdata_i);
    end
  end
endmodule

// File: rtl/ofi_run_timer.sv
module ofi_run_timer #(
  parameter int RUN_TICKS = 4,
  localparam int CNT_W = $clog2(RUN_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             osc_run_i,
  input  logic             stop_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_ok_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_TICKS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (!osc_run_i || stop_i) cnt_o <= '0;
    else if (tick_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end

  assign run_ok_o = (cnt_o == CNT_MAX);
endmodule

// File: rtl/ofi_fail_flag.sv
module ofi_fail_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_req_i,
  input  logic run_ok_i,
  output logic of_o
);
  // set dominates an honoured clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     of_o <= 1'b1;
    else if (set_i)                  of_o <= 1'b1;
    else if (clr_req_i && run_ok_i)  of_o <= 1'b0;
  end
endmodule

// File: rtl/ofi_pin_drv.sv
module ofi_pin_drv #(
  parameter int NS = 3
) (
  input  logic [NS-1:0] src_req_i,
  input  logic [NS-1:0] src_en_i,
  input  logic          out_bit_i,
  output logic          irq_mode_o,
  output logic          pull_low_o
);
  logic [NS-1:0] gated;
  for (genvar g = 0; g < NS; g++) begin : g_src
    assign gated[g] = src_req_i[g] & src_en_i[g];
  end

  assign irq_mode_o = |src_en_i;
  assign pull_low_o = irq_mode_o ? |gated : ~out_bit_i;
endmodule

// File: rtl/osc_fail_irq.sv
module osc_fail_irq
  import ofi_pkg::*;
#(
  parameter int RUN_TICKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_run_i,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              alm_req_i,
  input  logic              wdog_req_i,
  input  logic              wdog_en_i,
  output logic              stop_o,
  output logic              pull_low_o
);
  localparam int CNT_W = $clog2(RUN_TICKS + 1);

  ctrl_t            ctrl_q;
  logic             stop_wr;
  logic [CNT_W-1:0] run_cnt;
  logic             run_ok;
  logic             of_q;
  logic             of_set;
  logic             of_clr;
  logic             irq_mode;
  logic [N_SRC-1:0] src_req;
  logic [N_SRC-1:0] src_en;
  logic [DATA_W-1:0] rd_mux;

  ofi_ctrl_regs u_ctrl (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .ctrl_o(ctrl_q), .stop_wr_o(stop_wr)
  );

  ofi_run_timer #(.RUN_TICKS(RUN_TICKS)) u_timer (
    .clk_i, .rst_ni, .tick_i, .osc_run_i,
    .stop_i(ctrl_q.stop), .cnt_o(run_cnt), .run_ok_o(run_ok)
  );

  assign of_set = !osc_run_i || ctrl_q.stop || stop_wr;
  assign of_clr = wr_i && (addr_i == FLAG_ADDR) && !wdata_i[OF_B];

  ofi_fail_flag u_flag (
    .clk_i, .rst_ni, .set_i(of_set), .clr_req_i(of_clr),
    .run_ok_i(run_ok), .of_o(of_q)
  );

  always_comb begin
    src_req          = '0;
    src_en           = '0;
    src_req[SRC_OF]  = of_q;
    src_en[SRC_OF]   = ctrl_q.ofie;
    src_req[SRC_ALM] = alm_req_i;
    src_en[SRC_ALM]  = ctrl_q.afe;
    src_req[SRC_WDG] = wdog_req_i;
    src_en[SRC_WDG]  = wdog_en_i;
  end

  ofi_pin_drv #(.NS(N_SRC)) u_pin (
    .src_req_i(src_req), .src_en_i(src_en), .out_bit_i(ctrl_q.out_bit),
    .irq_mode_o(irq_mode), .pull_low_o(pull_low_o)
  );

  always_comb begin
    rd_mux = '0;
    if (addr_i == CTRL_ADDR) begin
      rd_mux = DATA_W'(ctrl_q);
    end else begin
      rd_mux[OF_B]    = of_q;
      rd_mux[RUNOK_B] = run_ok;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  assign stop_o = ctrl_q.stop;
endmodule

// File: rtl/osc_fail_irq_chk.sv
module osc_fail_irq_chk #(
  parameter int RUN_TICKS = 4,
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             osc_run_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic             addr_i,
  input logic [3:0]       wdata_i,
  input logic             of_q,
  input logic             ofie,
  input logic             afe,
  input logic             out_bit,
  input logic             wdog_en_i,
  input logic [CNT_W-1:0] run_cnt,
  input logic             pull_low_o
);
  logic clr_wr;
  assign clr_wr = wr_i && addr_i && !wdata_i[0];

  // R2
  of_set_on_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_run_i |=> of_q);

  // R3
  stop_write_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && wdata_i[0]) |=> of_q);

  // R4
  of_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (of_q && !clr_wr) |=> of_q);

  // R5
  early_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (of_q && run_cnt < CNT_W'(RUN_TICKS)) |=> of_q);

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt <= CNT_W'(RUN_TICKS));

  // R7
  of_irq_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (of_q && ofie) |-> pull_low_o);

  // R9
  out_mode_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ofie || afe || wdog_en_i) |-> (pull_low_o == !out_bit));

  // R4
  read_keeps_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && osc_run_i && $stable(pull_low_o)) |=> $stable(of_q));
endmodule

bind osc_fail_irq osc_fail_irq_chk #(.RUN_TICKS(RUN_TICKS), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .osc_run_i(osc_run_i), .wr_i(wr_i),
  .rd_i(rd_i), .addr_i(addr_i), .wdata_i(wdata_i), .of_q(of_q),
  .ofie(ctrl_q.ofie), .afe(ctrl_q.afe), .out_bit(ctrl_q.out_bit),
  .wdog_en_i(wdog_en_i), .run_cnt(run_cnt), .pull_low_o(pull_low_o)
);

// File: tb/osc_fail_irq_bench.sv
module osc_fail_irq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_run = 1'b1, tick = 1'b0, wr = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic alm = 1'b0, wq = 1'b0, wen = 1'b0;
  logic stop, pull_low;
  wire  irq_pin = pull_low ? 1'b0 : 1'b1;  // external pull-up
  int   n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  osc_fail_irq u_osc_fail_irq (
    .clk_i(clk), .rst_ni(rst_n), .osc_run_i(osc_run), .tick_i(tick),
    .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .alm_req_i(alm), .wdog_req_i(wq), .wdog_en_i(wen),
    .stop_o(stop), .pull_low_o(pull_low)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [3:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [3:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  function automatic logic exp_pin(logic of, logic ofie, logic afe, logic ob,
                                   logic we, logic al, logic w);
    logic irq_mode = ofie | afe | we;
    logic irq = (of & ofie) | (al & afe) | (w & we);
    return irq_mode ? ~irq : ob;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] d;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 pin", {3'b0, irq_pin}, 4'h1);
    chk("R1 stop", {3'b0, stop}, 4'h0);
    chk("R1 rdata", rdata, 4'h0);
    rst_n = 1'b1;
    rd_reg(1'b0, d); chk("R1 ctrl", d, 4'b1000);
    rd_reg(1'b1, d); chk("R1 flag", d[0+:1], 1'b1);

    // R5 early clear ignored, on-time clear honoured
    ticks(3);
    wr_reg(1'b1, 4'h0);
    rd_reg(1'b1, d); chk("R5 early", d, 4'b0001);
    ticks(1);
    rd_reg(1'b1, d); chk("R10 runok", d, 4'b0011);
    wr_reg(1'b1, 4'h0);
    rd_reg(1'b1, d); chk("R5 ontime", d, 4'b0010);

    // R4 write of 1 does nothing
    wr_reg(1'b1, 4'h1);
    rd_reg(1'b1, d); chk("R4 wr1", d[0+:1], 1'b0);

    // R2 stop event sets flag and restarts timer
    @(negedge clk); osc_run = 1'b0;
    ticks(2);
    @(negedge clk); osc_run = 1'b1;
    rd_reg(1'b1, d); chk("R2 set", d, 4'b0001);
    ticks(3);
    wr_reg(1'b1, 4'h0);
    rd_reg(1'b1, d); chk("R2 restart", d, 4'b0001);
    ticks(1);
    wr_reg(1'b1, 4'h0);
    rd_reg(1'b1, d); chk("R2 clear", d[0+:1], 1'b0);

    // R6 set and clear on same edge
    @(negedge clk); osc_run = 1'b0; wr = 1'b1; addr = 1'b1; wdata = 4'h0;
    @(negedge clk); osc_run = 1'b1; wr = 1'b0;
    rd_reg(1'b1, d); chk("R6 set wins", d[0+:1], 1'b1);

    // R3 stop bit
    ticks(4);
    wr_reg(1'b0, 4'b1001);
    chk("R3 stop_o", {3'b0, stop}, 4'h1);
    rd_reg(1'b1, d); chk("R3 flag", d, 4'b0001);
    ticks(5);
    wr_reg(1'b0, 4'b1000);
    chk("R3 release", {3'b0, stop}, 4'h0);
    wr_reg(1'b1, 4'h0);
    rd_reg(1'b1, d); chk("R3 held", d[0+:1], 1'b1);
    ticks(4);

    // R7 / R4: OF irq, read does not clear
    wr_reg(1'b0, 4'b1010);
    chk("R7 low", {3'b0, irq_pin}, 4'h0);
    rd_reg(1'b1, d); chk("R4 read", d[0+:1], 1'b1);
    chk("R4 pin", {3'b0, irq_pin}, 4'h0);
    wr_reg(1'b0, 4'b1000);
    chk("R7 ofie off", {3'b0, irq_pin}, 4'h1);
    wr_reg(1'b0, 4'b1010);
    wr_reg(1'b1, 4'h0);
    chk("R7 of off", {3'b0, irq_pin}, 4'h1);

    // R8 / R9 sweep, flag at 0 then at 1
    for (int of = 0; of < 2; of++) begin
      if (of == 1) begin
        @(negedge clk); osc_run = 1'b0;
        @(negedge clk); osc_run = 1'b1;
      end
      for (int c = 0; c < 64; c++) begin
        logic ofie = c[0], afe = c[1], ob = c[2];
        @(negedge clk);
        wen = c[3]; alm = c[4]; wq = c[5];
        wr = 1'b1; addr = 1'b0; wdata = {ob, afe, ofie, 1'b0};
        @(negedge clk); wr = 1'b0;
        chk((ofie | afe | c[3]) ? "R8 irq" : "R9 out", {3'b0, irq_pin},
            {3'b0, exp_pin(of[0], ofie, afe, ob, c[3], c[4], c[5])});
        if (c % 16 == 5) begin
          rd_reg(1'b0, d); chk("R10 ctrl", d, {ob, afe, ofie, 1'b0});
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule